// File: doc/BRIEF.md
# Multi-Port Register Space Decoder

This block sits between a single memory-mapped configuration master and the register slaves of a multi-channel Ethernet subsystem. The master issues 32-bit reads and writes on a 20-bit byte address. The decoder looks up the address in a two-level map and forwards the access to one slave with a window-relative offset. At the top level the map holds a client region, a reconfiguration-controller region, a reserved page and a set of replicated channel pages. Each channel page is split into four windows: PHY, receive FIFO, transmit FIFO and MAC.

Only one access is in flight at a time. The master's command is registered. The chosen slave is strobed until it drops its waitrequest. The slave's read data is then captured into a register and the master is released for one cycle. Addresses that decode to nothing complete after a single cycle and never touch a slave. The number of decoded channels is a parameter from 1 to 12.

Top module: `regspace_router`

## Requirements
- R1: A word-aligned address below 0x0F000 goes to target 0 (client), and the local offset equals the full address.
- R2: A word-aligned address from 0x0F000 to 0x0FFFF goes to target 1 (reconfiguration), with local offset = address − 0x0F000.
- R3: Channel n (n < NUM_PORTS) owns page 0x20000 + n·0x10000. Within that page the windows are: sub-offset 0x4000–0x75FF is the PHY at target 2+4n; 0x7600–0x76FF is the RX FIFO at 2+4n+1; 0x7700–0x77FF is the TX FIFO at 2+4n+2; 0x8000–0xFFFF is the MAC at 2+4n+3. The local offset is the sub-offset minus the window start.
- R4: A word-aligned address at or above 0xE0000 goes to target 0 (client), and the local offset equals the full address.
- R5: The following addresses are undecodable: the page 0x10000–0x1FFFF; channel sub-offsets 0x0000–0x3FFF and 0x7800–0x7FFF; any channel page whose index is NUM_PORTS or higher; and any address with bits [1:0] non-zero. An access to one of them strobes no slave. The master sees waitrequest low in the cycle after the one in which the request was first presented. A read returns 0xDEADBEEF.
- R6: A write to an undecodable address changes no slave's contents.
- R7: Take a decodable access presented in cycle 0, to a slave that holds waitrequest high for s cycles of its strobe. The master's waitrequest is high until cycle 1+s and low in cycle 2+s. While the slave stalls, its strobe and offset hold steady.
- R8: Master readdata is registered. It is 0 after reset and changes only in a completion cycle of a read. A completed write leaves it at the last read value.
- R9: At most one slave strobe is high at a time. No strobe is high while the master's waitrequest is low, and a strobe is high only while the master holds its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_addr | input | ADDR_W | Master byte address |
| m_read | input | 1 | Master read request |
| m_write | input | 1 | Master write request |
| m_wdata | input | DATA_W | Master write data |
| m_rdata | output | DATA_W | Registered read data |
| m_waitrequest | output | 1 | High while the access cannot complete |
| s_addr | output | ADDR_W | Window-relative offset to the selected slave |
| s_wdata | output | DATA_W | Write data to slaves |
| s_read | output | NUM_TGT | Per-target read strobes |
| s_write | output | NUM_TGT | Per-target write strobes |
| s_rdata | input | NUM_TGT·DATA_W | Per-target read data, target t in bits [32t+31:32t] |
| s_waitrequest | input | NUM_TGT | Per-target waitrequest |

## Verification
The bench builds the decoder with NUM_PORTS = 3. With that value, channel page 3 at 0x50000 lies past the last active channel and must fall into the undecodable path. The three active channels let the bench check that the target index advances by four per page, with a different window checked on each channel. The slave stall is a runtime setting in the bench, which exercises both the zero-wait latency and the stretched latency.

// File: rtl/regspace_pkg.sv
package regspace_pkg;

   // fixed map constants (byte addresses)
   localparam int MAX_PORTS      = 12;
   localparam int FIXED_TGTS     = 2;
   localparam int WIN_PER_PORT   = 4;
   localparam int PAGE_LSB       = 16;
   localparam int RCFG_BASE      = 'h0F000;
   localparam int RSV_PAGE       = 1;
   localparam int CH_FIRST_PAGE  = 2;
   localparam int CLIENT_HI_PAGE = 'hE;
   localparam int PHY_BASE       = 'h4000;
   localparam int RXF_BASE       = 'h7600;
   localparam int TXF_BASE       = 'h7700;
   localparam int HOLE_BASE      = 'h7800;
   localparam int MAC_BASE       = 'h8000;
   localparam logic [31:0] FILL_WORD = 32'hDEAD_BEEF;

   typedef enum logic [1:0] {
      WIN_PHY = 2'd0,
      WIN_RXF = 2'd1,
      WIN_TXF = 2'd2,
      WIN_MAC = 2'd3
   } win_kind_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_BUSY = 2'd1,
      ST_DONE = 2'd2
   } xfer_st_t;

endpackage

// File: rtl/region_decode.sv
module region_decode
   import regspace_pkg::*;
#(
   parameter int ADDR_W    = 20,
   parameter int NUM_PORTS = 2,
   parameter int TGT_W     = 4
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [TGT_W-1:0]  tgt,
   output logic [ADDR_W-1:0] local_off
);

   localparam int PG_W  = ADDR_W - PAGE_LSB;
   localparam int SUB_W = PAGE_LSB;

   logic [PG_W-1:0]      page;
   logic [SUB_W-1:0]     sub;
   logic [NUM_PORTS-1:0] ch_hit;
   logic [3:0]           ch_idx;
   logic                 sub_ok;
   win_kind_t            kind;
   logic [SUB_W-1:0]     win_base;

   assign page = addr[ADDR_W-1:PAGE_LSB];
   assign sub  = addr[SUB_W-1:0];

   // one page comparator per active channel
   for (genvar n = 0; n < NUM_PORTS; n++) begin : g_ch
      assign ch_hit[n] = (page == PG_W'(CH_FIRST_PAGE + n));
   end

   always_comb begin
      ch_idx = '0;
      for (int n = 0; n < NUM_PORTS; n++) begin
         if (ch_hit[n]) ch_idx = 4'(n);
      end
   end

   // window inside a channel page
   always_comb begin
      sub_ok   = 1'b1;
      kind     = WIN_PHY;
      win_base = SUB_W'(PHY_BASE);
      if (sub >= SUB_W'(MAC_BASE)) begin
         kind     = WIN_MAC;
         win_base = SUB_W'(MAC_BASE);
      end else if (sub >= SUB_W'(HOLE_BASE)) begin
         sub_ok = 1'b0;
      end else if (sub >= SUB_W'(TXF_BASE)) begin
         kind     = WIN_TXF;
         win_base = SUB_W'(TXF_BASE);
      end else if (sub >= SUB_W'(RXF_BASE)) begin
         kind     = WIN_RXF;
         win_base = SUB_W'(RXF_BASE);
      end else if (sub < SUB_W'(PHY_BASE)) begin
         sub_ok = 1'b0;
      end
   end

   always_comb begin
      hit       = 1'b0;
      tgt       = '0;
      local_off = addr;
      if (addr[1:0] != 2'b00) begin
         hit = 1'b0;
      end else if (addr < ADDR_W'(RCFG_BASE)) begin
         hit = 1'b1;
      end else if (page == '0) begin
         hit       = 1'b1;
         tgt       = TGT_W'(1);
         local_off = addr - ADDR_W'(RCFG_BASE);
      end else if (page == PG_W'(RSV_PAGE)) begin
         hit = 1'b0;
      end else if (page >= PG_W'(CLIENT_HI_PAGE)) begin
         hit = 1'b1;
      end else if ((|ch_hit) && sub_ok) begin
         hit       = 1'b1;
         tgt       = TGT_W'(FIXED_TGTS) + TGT_W'({ch_idx, 2'b00}) + TGT_W'(kind);
         local_off = ADDR_W'(sub - win_base);
      end
   end

endmodule

// File: rtl/txn_ctrl.sv
module txn_ctrl
   import regspace_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 32,
   parameter int TGT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              m_read,
   input  logic              m_write,
   input  logic [DATA_W-1:0] m_wdata,
   input  logic              dec_hit,
   input  logic [TGT_W-1:0]  dec_tgt,
   input  logic [ADDR_W-1:0] dec_local,
   input  logic              sel_wait,
   input  logic [DATA_W-1:0] sel_rdata,
   output logic              m_waitrequest,
   output logic [DATA_W-1:0] m_rdata,
   output logic              busy,
   output logic              cmd_rd,
   output logic              cmd_wr,
   output logic [TGT_W-1:0]  cmd_tgt,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [DATA_W-1:0] cmd_wdata
);

   xfer_st_t st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         cmd_rd    <= 1'b0;
         cmd_wr    <= 1'b0;
         cmd_tgt   <= '0;
         cmd_addr  <= '0;
         cmd_wdata <= '0;
         m_rdata   <= '0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (m_read || m_write) begin
                  cmd_rd    <= m_read;
                  cmd_wr    <= m_write & ~m_read;
                  cmd_tgt   <= dec_tgt;
                  cmd_addr  <= dec_local;
                  cmd_wdata <= m_wdata;
                  if (dec_hit) begin
                     st <= ST_BUSY;
                  end else begin
                     st <= ST_DONE;
                     if (m_read) m_rdata <= DATA_W'(FILL_WORD);
                  end
               end
            end
            ST_BUSY: begin
               if (!sel_wait) begin
                  if (cmd_rd) m_rdata <= sel_rdata;
                  st <= ST_DONE;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign m_waitrequest = (st != ST_DONE);
   assign busy          = (st == ST_BUSY);

endmodule

// File: rtl/rdata_mux.sv
module rdata_mux #(
   parameter int DATA_W  = 32,
   parameter int NUM_TGT = 10,
   parameter int TGT_W   = 4
) (
   input  logic [TGT_W-1:0]          sel,
   input  logic [NUM_TGT*DATA_W-1:0] s_rdata,
   input  logic [NUM_TGT-1:0]        s_waitrequest,
   output logic [DATA_W-1:0]         sel_rdata,
   output logic                      sel_wait
);

   logic [DATA_W-1:0]  masked [NUM_TGT];
   logic [NUM_TGT-1:0] wmask;

   for (genvar t = 0; t < NUM_TGT; t++) begin : g_leg
      assign masked[t] = (sel == TGT_W'(t)) ? s_rdata[t*DATA_W +: DATA_W] : '0;
      assign wmask[t]  = (sel == TGT_W'(t)) & s_waitrequest[t];
   end

   always_comb begin
      sel_rdata = '0;
      for (int t = 0; t < NUM_TGT; t++) sel_rdata = sel_rdata | masked[t];
   end

   assign sel_wait = |wmask;

endmodule

// File: rtl/regspace_router.sv
module regspace_router
   import regspace_pkg::*;
#(
   parameter  int ADDR_W    = 20,
   parameter  int DATA_W    = 32,
   parameter  int NUM_PORTS = 2,
   localparam int NUM_TGT   = FIXED_TGTS + WIN_PER_PORT * NUM_PORTS
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [ADDR_W-1:0]         m_addr,
   input  logic                      m_read,
   input  logic                      m_write,
   input  logic [DATA_W-1:0]         m_wdata,
   output logic [DATA_W-1:0]         m_rdata,
   output logic                      m_waitrequest,
   output logic [ADDR_W-1:0]         s_addr,
   output logic [DATA_W-1:0]         s_wdata,
   output logic [NUM_TGT-1:0]        s_read,
   output logic [NUM_TGT-1:0]        s_write,
   input  logic [NUM_TGT*DATA_W-1:0] s_rdata,
   input  logic [NUM_TGT-1:0]        s_waitrequest
);

   localparam int TGT_W = $clog2(NUM_TGT);

   if (NUM_PORTS < 1 || NUM_PORTS > MAX_PORTS) begin : g_bad_ports
      $error("regspace_router: NUM_PORTS must be 1..12");
   end
   if (ADDR_W != 20) begin : g_bad_addr
      $error("regspace_router: map is fixed to a 20-bit byte address");
   end
   if (DATA_W != 32) begin : g_bad_data
      $error("regspace_router: registers are 32 bits wide");
   end

   logic              dec_hit;
   logic [TGT_W-1:0]  dec_tgt;
   logic [ADDR_W-1:0] dec_local;
   logic              sel_wait;
   logic [DATA_W-1:0] sel_rdata;
   logic              busy;
   logic              cmd_rd;
   logic              cmd_wr;
   logic [TGT_W-1:0]  cmd_tgt;

   region_decode #(
      .ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS), .TGT_W(TGT_W)
   ) u_dec (
      .addr(m_addr), .hit(dec_hit), .tgt(dec_tgt), .local_off(dec_local)
   );

   txn_ctrl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TGT_W(TGT_W)
   ) u_ctl (
      .clk(clk), .rst_n(rst_n),
      .m_read(m_read), .m_write(m_write), .m_wdata(m_wdata),
      .dec_hit(dec_hit), .dec_tgt(dec_tgt), .dec_local(dec_local),
      .sel_wait(sel_wait), .sel_rdata(sel_rdata),
      .m_waitrequest(m_waitrequest), .m_rdata(m_rdata),
      .busy(busy), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_tgt(cmd_tgt),
      .cmd_addr(s_addr), .cmd_wdata(s_wdata)
   );

   rdata_mux #(
      .DATA_W(DATA_W), .NUM_TGT(NUM_TGT), .TGT_W(TGT_W)
   ) u_mux (
      .sel(cmd_tgt), .s_rdata(s_rdata), .s_waitrequest(s_waitrequest),
      .sel_rdata(sel_rdata), .sel_wait(sel_wait)
   );

   for (genvar t = 0; t < NUM_TGT; t++) begin : g_strobe
      assign s_read[t]  = busy & cmd_rd & (cmd_tgt == TGT_W'(t));
      assign s_write[t] = busy & cmd_wr & (cmd_tgt == TGT_W'(t));
   end

endmodule

// File: rtl/regspace_router_chk.sv
module regspace_router_chk #(
   parameter int ADDR_W  = 20,
   parameter int DATA_W  = 32,
   parameter int NUM_TGT = 10
) (
   input logic               clk,
   input logic               rst_n,
   input logic               m_read,
   input logic               m_write,
   input logic [DATA_W-1:0]  m_rdata,
   input logic               m_waitrequest,
   input logic [ADDR_W-1:0]  s_addr,
   input logic [NUM_TGT-1:0] s_read,
   input logic [NUM_TGT-1:0] s_write,
   input logic [NUM_TGT-1:0] s_waitrequest
);

   logic [NUM_TGT-1:0] strb;
   assign strb = s_read | s_write;

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(strb) <= 1); // R9

   AST_NO_STROBE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !m_waitrequest |-> (strb == '0)); // R9

   AST_STROBE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (|strb) |-> (m_read || m_write)); // R9

   AST_STROBE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (|(strb & s_waitrequest)) |=> ($stable(s_read) && $stable(s_write) && $stable(s_addr))); // R7

   AST_COMPLETE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (|(strb & ~s_waitrequest)) |=> !m_waitrequest); // R7

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      !m_waitrequest |=> m_waitrequest); // R5

   AST_RDATA_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(m_rdata) |-> !m_waitrequest); // R8

endmodule

bind regspace_router regspace_router_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_TGT(NUM_TGT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .m_read(m_read), .m_write(m_write),
   .m_rdata(m_rdata), .m_waitrequest(m_waitrequest), .s_addr(s_addr),
   .s_read(s_read), .s_write(s_write), .s_waitrequest(s_waitrequest)
);

// File: tb/sim_regspace_router.sv
module sim_regspace_router;

   localparam int NP = 3;
   localparam int NT = 2 + 4 * NP;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [19:0]     m_addr = '0;
   logic            m_read = 1'b0;
   logic            m_write = 1'b0;
   logic [31:0]     m_wdata = '0;
   logic [31:0]     m_rdata;
   logic            m_waitrequest;
   logic [19:0]     s_addr;
   logic [31:0]     s_wdata;
   logic [NT-1:0]   s_read;
   logic [NT-1:0]   s_write;
   logic [NT*32-1:0] s_rdata;
   logic [NT-1:0]   s_waitrequest;

   always #2 clk = ~clk;

   regspace_router #(.ADDR_W(20), .DATA_W(32), .NUM_PORTS(NP)) u0 (
      .clk(clk), .rst_n(rst_n), .m_addr(m_addr), .m_read(m_read),
      .m_write(m_write), .m_wdata(m_wdata), .m_rdata(m_rdata),
      .m_waitrequest(m_waitrequest), .s_addr(s_addr), .s_wdata(s_wdata),
      .s_read(s_read), .s_write(s_write), .s_rdata(s_rdata),
      .s_waitrequest(s_waitrequest)
   );

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   // ---------------- slave models ----------------
   int          stall_cfg = 0;
   int          scnt = 0;
   logic [31:0] smem [NT][64];
   bit          sval [NT][64];

   always @(posedge clk) begin
      if (|(s_read | s_write)) scnt <= scnt + 1;
      else scnt <= 0;
   end
   assign s_waitrequest = (scnt < stall_cfg) ? '1 : '0;

   for (genvar t = 0; t < NT; t++) begin : g_slv
      assign s_rdata[t*32 +: 32] = sval[t][s_addr[7:2]] ? smem[t][s_addr[7:2]]
                                                        : {8'(t), 4'h0, s_addr};
      always @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < 64; i++) sval[t][i] <= 1'b0;
         end else if (s_write[t] && !s_waitrequest[t]) begin
            smem[t][s_addr[7:2]] <= s_wdata;
            sval[t][s_addr[7:2]] <= 1'b1;
         end
      end
   end

   // ---------------- expected map ----------------
   function automatic void exp_map(input logic [19:0] a, output int tgt,
                                   output logic [19:0] loc);
      int pg;
      int off;
      pg  = int'(a[19:16]);
      off = int'(a[15:0]);
      tgt = -1;
      loc = '0;
      if (a[1:0] != 0) return;
      if (a < 20'h0F000) begin tgt = 0; loc = a; end
      else if (pg == 0) begin tgt = 1; loc = a - 20'h0F000; end
      else if (pg == 1) tgt = -1;
      else if (pg >= 14) begin tgt = 0; loc = a; end
      else if (pg - 2 < NP) begin
         if (off >= 'h8000)      begin tgt = 2 + 4*(pg-2) + 3; loc = 20'(off - 'h8000); end
         else if (off >= 'h7800) tgt = -1;
         else if (off >= 'h7700) begin tgt = 2 + 4*(pg-2) + 2; loc = 20'(off - 'h7700); end
         else if (off >= 'h7600) begin tgt = 2 + 4*(pg-2) + 1; loc = 20'(off - 'h7600); end
         else if (off >= 'h4000) begin tgt = 2 + 4*(pg-2);     loc = 20'(off - 'h4000); end
      end
   endfunction

   logic [31:0] mdl_d [NT][64];
   bit          mdl_v [NT][64];
   logic [31:0] last_rd = 32'h0;

   typedef struct {
      bit          is_rd;
      int          tgt;
      logic [19:0] loc;
      logic [31:0] data;
      int          waits;
      string       req;
   } exp_t;
   exp_t sb[$];
   int   n_done = 0;

   // ---------------- driver ----------------
   task automatic access(input bit is_rd, input logic [19:0] a,
                         input logic [31:0] d, input int stall, input string req);
      exp_t e;
      int   t;
      logic [19:0] l;
      int   c;
      exp_map(a, t, l);
      e.is_rd = is_rd; e.tgt = t; e.loc = l; e.req = req;
      e.waits = (t < 0) ? 1 : 2 + stall;
      if (is_rd) begin
         if (t < 0) e.data = 32'hDEAD_BEEF;
         else if (mdl_v[t][l[7:2]]) e.data = mdl_d[t][l[7:2]];
         else e.data = {8'(t), 4'h0, l};
         last_rd = e.data;
      end else begin
         e.data = last_rd;
         if (t >= 0) begin mdl_d[t][l[7:2]] = d; mdl_v[t][l[7:2]] = 1'b1; end
      end
      sb.push_back(e);
      @(negedge clk);
      stall_cfg = stall;
      m_addr = a; m_wdata = d; m_read = is_rd; m_write = !is_rd;
      c = n_done;
      while (n_done == c) @(negedge clk);
      m_read = 1'b0; m_write = 1'b0;
   endtask

   // ---------------- monitor ----------------
   initial begin
      int          waits;
      int          seen_t;
      logic [19:0] seen_l;
      exp_t        e;
      waits = 0; seen_t = -1; seen_l = '0;
      forever begin
         @(negedge clk);
         #1;
         if (rst_n) begin
            if ((|(s_read | s_write)) && seen_t < 0) begin
               for (int t = 0; t < NT; t++)
                  if (s_read[t] || s_write[t]) seen_t = t;
               seen_l = s_addr;
            end
            if (m_read || m_write) begin
               if (m_waitrequest) waits++;
               else begin
                  if (sb.size() == 0) chk(0, "R9 unexpected completion", 0, 0);
                  else begin
                     e = sb.pop_front();
                     chk(seen_t == e.tgt, {e.req, " target"}, 32'(seen_t), 32'(e.tgt));
                     if (e.tgt >= 0)
                        chk(seen_l == e.loc, {e.req, " local offset"}, 32'(seen_l), 32'(e.loc));
                     chk(waits == e.waits, {e.req, " R7 latency"}, 32'(waits), 32'(e.waits));
                     chk(m_rdata == e.data, {e.req, (e.is_rd ? " readdata" : " R8 rdata hold")},
                         m_rdata, e.data);
                  end
                  waits = 0; seen_t = -1; n_done++;
               end
            end
         end
      end
   end

   // ---------------- watchdog ----------------
   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         chk(0, "watchdog expired", 0, 0);
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      for (int t = 0; t < NT; t++)
         for (int i = 0; i < 64; i++) mdl_v[t][i] = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk(m_waitrequest == 1'b1, "R8 reset waitrequest", 32'(m_waitrequest), 1);
      chk(m_rdata == 32'h0, "R8 reset readdata", m_rdata, 0);
      chk((s_read | s_write) == '0, "R9 reset strobes", 32'(s_read | s_write), 0);

      access(1, 20'h00010, 0, 0, "R1 client low read");
      access(0, 20'h0EFFC, 32'h1234_5678, 0, "R1 client write");
      access(1, 20'h0EFFC, 0, 0, "R1 client readback");
      access(1, 20'h0F000, 0, 0, "R2 reconfig base");
      access(1, 20'h0FFFC, 0, 0, "R2 reconfig top");
      access(1, 20'h24000, 0, 0, "R3 ch0 PHY base");
      access(1, 20'h275FC, 0, 0, "R3 ch0 PHY top");
      access(1, 20'h37604, 0, 0, "R3 ch1 RX FIFO");
      access(1, 20'h377F0, 0, 0, "R3 ch1 TX FIFO");
      access(1, 20'h4FFFC, 0, 0, "R3 ch2 MAC top");
      access(1, 20'hE0000, 0, 0, "R4 client high base");
      access(1, 20'hFFFFC, 0, 0, "R4 client high top");
      access(1, 20'h10000, 0, 0, "R5 reserved page");
      access(1, 20'h54000, 0, 0, "R5 channel past NUM_PORTS");
      access(1, 20'h27800, 0, 0, "R5 channel hole");
      access(1, 20'h27A00, 0, 0, "R5 channel gap");
      access(1, 20'h20000, 0, 0, "R5 channel low reserved");
      access(1, 20'h24002, 0, 0, "R5 misaligned");
      access(0, 20'h10004, 32'hAAAA_5555, 0, "R6 write reserved page");
      access(0, 20'h24006, 32'hBBBB_6666, 0, "R6 write misaligned");
      access(0, 20'h54004, 32'hCCCC_7777, 0, "R6 write past channels");
      access(1, 20'h00004, 0, 0, "R6 client untouched");
      access(1, 20'h24004, 0, 0, "R6 PHY untouched");
      access(0, 20'h48010, 32'h0BAD_F00D, 3, "R7 stalled MAC write");
      access(1, 20'h48010, 0, 5, "R7 stalled MAC readback");
      access(0, 20'h0F010, 32'h5A5A_0001, 1, "R8 write keeps rdata");
      access(1, 20'h0F010, 0, 0, "R8 reconfig readback");

      repeat (4) @(negedge clk);
      chk(sb.size() == 0, "R9 scoreboard drained", 32'(sb.size()), 0);
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule